// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the instruction fetch address for a small accumulator-style processor core. It keeps a 13-bit program counter. The low eight bits of the counter can be read and written as a byte register. The upper five bits cannot be read. They are loaded only from a separate write-only page latch. The core drives decoded strobes and operands into the block, and the block advances, jumps, calls, returns or vectors the counter on the next clock edge.

Short branch targets are eleven bits wide. The two page bits above them come from the top of the page latch. A write to the low byte takes all five latch bits as the upper address. Return addresses are held on an eight-entry hardware stack that wraps around silently. It has no overflow or underflow indication. A parameter sets the size of the implemented program memory. When that size is smaller than the counter's range, the fetch address wraps inside the implemented space.

Top module: `prog_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, the counter, the page latch and the stack pointer are zero. `fetch_addr` and `pc_lo` therefore read 0.
- R2: `adv` alone increments the counter by one across all 13 bits. 1FFFh is followed by 0000h.
- R3: `lo_wr` loads the counter with {page latch[4:0], `lo_wdata`}. `pc_lo` always shows counter bits 7:0.
- R4: `jump` loads counter bits 10:0 from `target` and counter bits 12:11 from page latch bits 4:3.
- R5: `call` loads the counter exactly as `jump` does. It also pushes the counter value plus one onto the return stack.
- R6: `ret` loads the counter from the most recently pushed stack entry and removes that entry. The stack has eight entries and is circular: push nine overwrites push one, push ten overwrites push two. A pop from an empty stack returns whichever entry the pointer wraps onto, with no flag.
- R7: `irq_take` loads the counter with 0004h and pushes the counter value plus one.
- R8: When several strobes are high in one cycle, exactly one load happens. The priority is `irq_take`, then `ret`, then `call`, then `jump`, then `lo_wr`, then `adv`. With no strobe high, the counter holds.
- R9: Only `hi_wr` changes the page latch, and it takes `hi_wdata`. A load in the same cycle as `hi_wr` uses the latch value from before the write. The other strobes leave the latch unchanged.
- R10: With `MEM_WORDS` = 4096, `fetch_addr` is the counter modulo 4096, so bit 12 reads 0. `pc_lo` is unaffected. With `MEM_WORDS` = 8192, `fetch_addr` equals the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv | input | 1 | Sequential increment |
| lo_wr | input | 1 | Write to the readable low address byte |
| lo_wdata | input | 8 | Data for the low byte write |
| hi_wr | input | 1 | Write to the page latch |
| hi_wdata | input | 5 | Data for the page latch |
| jump | input | 1 | Short jump to `target` |
| call | input | 1 | Short call to `target`, pushing the return address |
| ret | input | 1 | Return from the stack |
| irq_take | input | 1 | Interrupt entry to the vector, pushing the return address |
| target | input | 11 | Short branch target from the instruction |
| fetch_addr | output | 13 | Program memory fetch address |
| pc_lo | output | 8 | Readable low byte of the counter |

## Verification
The bench builds two copies of the block on the same stimulus. One uses the full 8K-word memory size and the other `MEM_WORDS` = 4096. Comparing the two shows that the fetch address folds into the lower 4K while the counter and its readable low byte still run over the full 13 bits. Both copies use the default stack depth of eight. That makes nine or more nested calls, and pops past empty, short directed sequences that show the circular overwrite.

// File: rtl/pas_pkg.sv
// Package: shared types of the program address sequencer.
// Assumes: a single load source is selected per cycle by the top module.
package pas_pkg;
    typedef enum logic [2:0] {
        LD_HOLD,
        LD_INC,
        LD_LOW,
        LD_JUMP,
        LD_RET,
        LD_VEC
    } load_sel_t;
endpackage

// File: rtl/pas_ret_stack.sv
// Module: circular return-address stack.
// A push writes the slot under the pointer and moves the pointer up.
// A pop moves the pointer down. The entry below the pointer is always presented.
// Assumes: DEPTH is a power of two, so the pointer wraps without extra logic.
// Assumes: push and pop are never high together.
module pas_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] below;

    // Slot holding the most recent push.
    always_comb below = ptr_q - 1'b1;

    assign top = mem_q[below];

    // Pointer moves up on push and down on pop, wrapping modulo DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= '0;
        else if (push) ptr_q <= ptr_q + 1'b1;
        else if (pop)  ptr_q <= below;
    end

    // One storage register per slot; a push overwrites whatever the slot held.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                             mem_q[g] <= '0;
            else if (push && ptr_q == PTR_W'(g))    mem_q[g] <= din;
        end
    end
endmodule

// File: rtl/pas_next_pc.sv
// Module: next program counter selection.
// Builds the candidate address for every load kind and picks one by sel.
// Assumes: the page latch is LAT_W = PC_W - LOW_W bits wide.
// The page bits for a short target are the top PC_W - TGT_W bits of the latch.
module pas_next_pc
    import pas_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LOW_W = 8,
    parameter int TGT_W = 11,
    parameter int VEC   = 4
) (
    input  load_sel_t             sel,
    input  logic [PC_W-1:0]       pc,
    input  logic [PC_W-LOW_W-1:0] latch,
    input  logic [LOW_W-1:0]      lo_data,
    input  logic [TGT_W-1:0]      target,
    input  logic [PC_W-1:0]       stack_top,
    output logic [PC_W-1:0]       pc_next,
    output logic [PC_W-1:0]       pc_inc
);
    localparam int LAT_W  = PC_W - LOW_W;
    localparam int PAGE_W = PC_W - TGT_W;

    logic [PAGE_W-1:0] page;

    // Page bits used with a short branch target.
    always_comb page = latch[LAT_W-1 -: PAGE_W];

    // Increment wraps over the full counter width.
    always_comb pc_inc = pc + 1'b1;

    // One source per load kind.
    always_comb begin
        unique case (sel)
            LD_INC:  pc_next = pc_inc;
            LD_LOW:  pc_next = {latch, lo_data};
            LD_JUMP: pc_next = {page, target};
            LD_RET:  pc_next = stack_top;
            LD_VEC:  pc_next = PC_W'(VEC);
            default: pc_next = pc;
        endcase
    end
endmodule

// File: rtl/prog_addr_seq.sv
// Module: paged program address sequencer (top).
// Holds the program counter and the page latch.
// Applies one load per cycle by fixed priority and drives the fetch address.
// The fetch address is folded into MEM_WORDS.
// Assumes: MEM_WORDS is a power of two no larger than 2**PC_W.
// Assumes: STACK_DEPTH is a power of two.
module prog_addr_seq
    import pas_pkg::*;
#(
    parameter int PC_W        = 13,
    parameter int LOW_W       = 8,
    parameter int TGT_W       = 11,
    parameter int STACK_DEPTH = 8,
    parameter int MEM_WORDS   = 8192,
    parameter int IRQ_VEC     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic                  lo_wr,
    input  logic [LOW_W-1:0]      lo_wdata,
    input  logic                  hi_wr,
    input  logic [PC_W-LOW_W-1:0] hi_wdata,
    input  logic                  jump,
    input  logic                  call,
    input  logic                  ret,
    input  logic                  irq_take,
    input  logic [TGT_W-1:0]      target,
    output logic [PC_W-1:0]       fetch_addr,
    output logic [LOW_W-1:0]      pc_lo
);
    localparam int LAT_W  = PC_W - LOW_W;
    localparam int MEM_AW = $clog2(MEM_WORDS);

    logic [PC_W-1:0]  pc_q;
    logic [LAT_W-1:0] latch_q;
    logic [PC_W-1:0]  pc_next;
    logic [PC_W-1:0]  pc_inc;
    logic [PC_W-1:0]  stack_top;
    load_sel_t        sel;
    logic             do_push;
    logic             do_pop;

    // Fixed priority picks a single load kind per cycle.
    always_comb begin
        if (irq_take)          sel = LD_VEC;
        else if (ret)          sel = LD_RET;
        else if (call || jump) sel = LD_JUMP;
        else if (lo_wr)        sel = LD_LOW;
        else if (adv)          sel = LD_INC;
        else                   sel = LD_HOLD;
    end

    // Stack traffic follows the selected load, not the raw strobes.
    always_comb begin
        do_push = irq_take || (!ret && call);
        do_pop  = !irq_take && ret;
    end

    pas_next_pc #(
        .PC_W (PC_W),
        .LOW_W(LOW_W),
        .TGT_W(TGT_W),
        .VEC  (IRQ_VEC)
    ) u_next (
        .sel      (sel),
        .pc       (pc_q),
        .latch    (latch_q),
        .lo_data  (lo_wdata),
        .target   (target),
        .stack_top(stack_top),
        .pc_next  (pc_next),
        .pc_inc   (pc_inc)
    );

    pas_ret_stack #(
        .DEPTH(STACK_DEPTH),
        .W    (PC_W)
    ) u_stack (
        .clk  (clk),
        .rst_n(rst_n),
        .push (do_push),
        .pop  (do_pop),
        .din  (pc_inc),
        .top  (stack_top)
    );

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    // Page latch: written only by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q <= '0;
        else if (hi_wr) latch_q <= hi_wdata;
    end

    assign pc_lo = pc_q[LOW_W-1:0];

    // Fold the fetch address into the implemented memory size.
    if (MEM_AW < PC_W) begin : g_fold
        assign fetch_addr = {{(PC_W-MEM_AW){1'b0}}, pc_q[MEM_AW-1:0]};
    end else begin : g_full
        assign fetch_addr = pc_q;
    end
endmodule

// File: rtl/prog_addr_seq_chk.sv
// Module: assertion checker for prog_addr_seq, attached by bind.
// Assumes: it sees the internal counter and page latch through the bind connections.
module prog_addr_seq_chk #(
    parameter int PC_W  = 13,
    parameter int LOW_W = 8,
    parameter int TGT_W = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  adv,
    input logic                  lo_wr,
    input logic [LOW_W-1:0]      lo_wdata,
    input logic                  hi_wr,
    input logic                  jump,
    input logic                  call,
    input logic                  ret,
    input logic                  irq_take,
    input logic [TGT_W-1:0]      target,
    input logic [PC_W-1:0]       pc,
    input logic [PC_W-LOW_W-1:0] latch
);
    localparam int LAT_W = PC_W - LOW_W;

    logic adv_only, low_only, jump_only;

    // Single-strobe conditions used by the properties below.
    always_comb begin
        adv_only  = adv && !lo_wr && !jump && !call && !ret && !irq_take;
        low_only  = lo_wr && !jump && !call && !ret && !irq_take;
        jump_only = (jump || call) && !ret && !irq_take;
    end

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_only |=> pc == PC_W'($past(pc) + 1'b1));

    // R3
    low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_only |=> pc == {$past(latch), $past(lo_wdata)});

    // R4
    page_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_only |=> (pc[TGT_W-1:0] == $past(target)) &&
                      (pc[PC_W-1:TGT_W] == $past(latch[LAT_W-1 -: PC_W-TGT_W])));

    // R7
    irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> pc == PC_W'(4));

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr |=> $stable(latch));
endmodule

bind prog_addr_seq prog_addr_seq_chk #(
    .PC_W (PC_W),
    .LOW_W(LOW_W),
    .TGT_W(TGT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .lo_wr   (lo_wr),
    .lo_wdata(lo_wdata),
    .hi_wr   (hi_wr),
    .jump    (jump),
    .call    (call),
    .ret     (ret),
    .irq_take(irq_take),
    .target  (target),
    .pc      (pc_q),
    .latch   (latch_q)
);

// File: tb/sim_prog_addr_seq.sv
module sim_prog_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv = 0, lo_wr = 0, hi_wr = 0, jump = 0, call = 0, ret = 0, irq_take = 0;
    logic [7:0]  lo_wdata = '0;
    logic [4:0]  hi_wdata = '0;
    logic [10:0] target = '0;
    logic [12:0] fa0, fa1;
    logic [7:0]  lo0, lo1;

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    logic [12:0] pc_m;
    logic [4:0]  lat_m;
    logic [12:0] stk_m [8];
    logic [2:0]  sp_m;

    always #5 clk = ~clk;

    prog_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
        .hi_wr(hi_wr), .hi_wdata(hi_wdata), .jump(jump), .call(call), .ret(ret),
        .irq_take(irq_take), .target(target), .fetch_addr(fa0), .pc_lo(lo0)
    );

    prog_addr_seq #(.MEM_WORDS(4096)) u1 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
        .hi_wr(hi_wr), .hi_wdata(hi_wdata), .jump(jump), .call(call), .ret(ret),
        .irq_take(irq_take), .target(target), .fetch_addr(fa1), .pc_lo(lo1)
    );

    task automatic check(string req, logic [12:0] act, logic [12:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare all outputs of both instances against the model.
    task automatic check_all(string req);
        check(req, fa0, pc_m);
        check(req, {5'd0, lo0}, {5'd0, pc_m[7:0]});
        check({req, " R10"}, fa1, {1'b0, pc_m[11:0]});
        check({req, " R10"}, {5'd0, lo1}, {5'd0, pc_m[7:0]});
    endtask

    function automatic logic [12:0] short_tgt(logic [4:0] l, logic [10:0] t);
        return {l[4:3], t};
    endfunction

    // Drive one cycle of strobes, advance the model by the priority rules, and check.
    task automatic apply(string req, bit s, bit lw, bit hw, bit j, bit c, bit r, bit i,
                         logic [7:0] ld, logic [4:0] hd, logic [10:0] tg);
        logic [12:0] inc;
        adv = s; lo_wr = lw; hi_wr = hw; jump = j; call = c; ret = r; irq_take = i;
        lo_wdata = ld; hi_wdata = hd; target = tg;
        @(posedge clk);
        inc = pc_m + 13'd1;
        if (i) begin
            stk_m[sp_m] = inc; sp_m = sp_m + 3'd1; pc_m = 13'h0004;
        end else if (r) begin
            sp_m = sp_m - 3'd1; pc_m = stk_m[sp_m];
        end else if (c) begin
            stk_m[sp_m] = inc; sp_m = sp_m + 3'd1; pc_m = short_tgt(lat_m, tg);
        end else if (j) begin
            pc_m = short_tgt(lat_m, tg);
        end else if (lw) begin
            pc_m = {lat_m, ld};
        end else if (s) begin
            pc_m = inc;
        end
        if (hw) lat_m = hd;
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        pc_m = '0; lat_m = '0; sp_m = '0;
        for (int k = 0; k < 8; k++) stk_m[k] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs are zero during reset and after release
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R6: pop on an empty stack lands on a reset slot, giving 0
        apply("R6 empty pop", 0,0,0,0,0,1,0, 8'h00, 5'h00, 11'h000);

        // R9 then R3: load the latch, then the low write uses it
        apply("R9 latch write", 0,0,1,0,0,0,0, 8'h00, 5'h1F, 11'h000);
        apply("R3 low write", 0,1,0,0,0,0,0, 8'hFF, 5'h00, 11'h000);
        // R2: wrap from 1FFF to 0000
        apply("R2 wrap", 1,0,0,0,0,0,0, 8'h00, 5'h00, 11'h000);
        // R9: same-cycle latch write does not affect the jump page
        apply("R9 same cycle", 0,0,1,1,0,0,0, 8'h00, 5'h08, 11'h123);
        apply("R4 jump page", 0,0,0,1,0,0,0, 8'h00, 5'h00, 11'h7FF);
        // R9: jump, call and ret leave the latch; a low write shows it
        apply("R9 latch kept", 0,1,0,0,0,0,0, 8'h5A, 5'h00, 11'h000);

        // R5, R6: ten nested calls, then ten returns over the circular stack
        for (int k = 0; k < 10; k++)
            apply("R5 nested call", 0,0,0,0,1,0,0, 8'h00, 5'(k), 11'(k * 37 + 5));
        for (int k = 0; k < 10; k++)
            apply("R6 circular return", 0,0,0,0,0,1,0, 8'h00, 5'h00, 11'h000);

        // R7 and R8: interrupt beats every other strobe
        apply("R8 irq priority", 1,1,0,1,1,1,1, 8'h33, 5'h00, 11'h222);
        apply("R6 return from irq", 0,0,0,0,0,1,0, 8'h00, 5'h00, 11'h000);
        apply("R8 ret over call", 1,1,0,1,1,1,0, 8'h44, 5'h00, 11'h111);
        apply("R8 hold", 0,0,0,0,0,0,0, 8'h00, 5'h00, 11'h000);

        // R10: a PC in the upper 4K folds in the smaller build
        apply("R10 latch hi", 0,0,1,0,0,0,0, 8'h00, 5'h1A, 11'h000);
        apply("R10 upper page", 0,1,0,0,0,0,0, 8'hC3, 5'h00, 11'h000);

        // Random mix over all strobes
        for (int n = 0; n < 3000; n++) begin
            int unsigned k = $urandom % 10;
            bit s = 0, lw = 0, j = 0, c = 0, r = 0, i = 0;
            bit hw = ($urandom % 4) == 0;
            case (k)
                0, 1, 2, 3: s = 1;
                4: lw = 1;
                5: j = 1;
                6: c = 1;
                7: r = 1;
                8: i = 1;
                default: begin
                    s = 1'($urandom); lw = 1'($urandom); j = 1'($urandom);
                    c = 1'($urandom); r = 1'($urandom); i = 1'($urandom);
                end
            endcase
            apply("R8 random mix", s, lw, hw, j, c, r, i,
                  8'($urandom), 5'($urandom), 11'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule